// File: doc/BRIEF.md
# Capture/Compare Timer with Protected Status Flags

This block is a free-running up-counter with a set of general registers. Each register works either as an input-capture register, which copies the counter value on a rising edge of its own external input, or as an output-compare register, which detects the counter reaching its stored value. Each register has a status flag that records its event. The counter has a separate flag that records a wrap from all ones to zero. A PWM setting turns register A into the period limit: on a match, the counter restarts from zero. In PWM mode none of the register flags can be raised.

Software reaches the block through a single-cycle register port. Read data is returned with a valid strobe one cycle after the read request. A status flag can be cleared only by a guarded two-step sequence. First, software reads the status register while the flag is 1, which arms that flag. Then a later write of 0 to that bit position clears it. This prevents a flag from being lost when it is raised between a read and a blind write.

Top module: `capcmp_timer`

## Requirements
- R1: When the run bit (control bit 0) is 1, the counter increases by one in every cycle. When the run bit is 0, the counter holds. A write to the counter address (1) loads the counter directly.
- R2: When the counter advances from 0xFFFF to 0x0000, the overflow flag (status bit 9) is set.
- R3: When a register is in capture mode (its control mode bit is 0: bit 1 for A, bit 2 for B, bit 3 for C), a rising edge on its capture input copies the counter into that register, after a two-stage synchroniser. The capture also sets its status flag: bit 10 for A, bit 11 for B, bit 12 for C.
- R4: When a register is in compare mode (its mode bit is 1), its status flag is set in any cycle where the counter advances while equal to that register's value.
- R5: When PWM mode is on (control bit 4), flags A, B and C are never set, and captures are ignored. A counter advance while the counter equals register A returns the counter to 0.
- R6: A flag is cleared by writing 0 to its bit at the status address (5), but only if a status read returned that flag as 1 beforehand. A write of 0 without such a read leaves the flag at 1.
- R7: Writing 1 to a status flag bit never changes that flag.
- R8: If a flag's set event and a valid clear fall in the same cycle, the flag remains 1.
- R9: After reset, all flags are 0, the counter is 0 and the control register is 0.
- R10: A read returns data with the valid strobe exactly one cycle after the request. The addresses are: control 0, counter 1, registers A/B/C at 2/3/4, status 5. Status bits other than 9 to 12 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| capIn | input | 3 | Asynchronous capture inputs for registers A, B, C |
| rdData | output | 16 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after regRd |

## Verification
The assertions check on every cycle the rules that relate state across a single edge:
- counter stepping and holding;
- overflow setting its flag;
- an unarmed flag never clearing;
- any capture or compare event outside PWM leaving its flag at 1, even when a clear arrives in the same cycle;
- PWM never raising a register flag;
- the one-cycle read response.

Only the bench scenarios can show the sequence-level behaviour:
- the captured value itself;
- the compare value matched over a counting window;
- the PWM period restart;
- the read-then-write-zero protocol across several accesses, including a partial clear that writes 1 to one armed flag and 0 to another.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int NUM_GR   = 3;
  localparam int NUM_FLAG = NUM_GR + 1;
  localparam int ADDR_W   = 3;

  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_CNT     = 1;
  localparam int ADDR_GR_BASE = 2;
  localparam int ADDR_STATUS  = ADDR_GR_BASE + NUM_GR;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_MODE_LSB = 1;
  localparam int CTL_PWM_BIT  = CTL_MODE_LSB + NUM_GR;

  // overflow flag sits at OVF_BIT, register flags follow directly above it
  localparam int OVF_BIT = 9;

  typedef struct packed {
    logic              cntLoad;
    logic [NUM_GR-1:0] grLoad;
    logic              countEn;
    logic              pwmMode;
    logic [NUM_GR-1:0] cmpMode;
  } ctlStrobes_t;
endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctlStrobes_t                   strobes,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [NUM_GR-1:0]             capIn,
  output logic [CNT_W-1:0]              cntVal,
  output logic [NUM_GR-1:0][CNT_W-1:0]  grVal,
  output logic [NUM_GR-1:0]             capEv,
  output logic [NUM_GR-1:0]             cmpEv,
  output logic                          ovfEv
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]             cntQ;
  logic [NUM_GR-1:0][CNT_W-1:0] grQ;
  logic [NUM_GR-1:0]            capMeta, capSync, capPrev, capRise;
  logic                         advance, pwmRestart;

  assign advance    = strobes.countEn && !strobes.cntLoad;
  assign pwmRestart = advance && strobes.pwmMode && (cntQ == grQ[0]);
  assign ovfEv      = advance && !pwmRestart && (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)                  cntQ <= '0;
    else if (strobes.cntLoad) cntQ <= wrData;
    else if (pwmRestart)      cntQ <= '0;
    else if (strobes.countEn) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capMeta <= '0;
      capSync <= '0;
      capPrev <= '0;
    end else begin
      capMeta <= capIn;
      capSync <= capMeta;
      capPrev <= capSync;
    end
  end

  assign capRise = capSync & ~capPrev;

  for (genvar g = 0; g < NUM_GR; g++) begin : gen_gr
    assign cmpEv[g] = advance && strobes.cmpMode[g] && (cntQ == grQ[g]);
    assign capEv[g] = capRise[g] && !strobes.cmpMode[g] && !strobes.pwmMode;

    always_ff @(posedge clk) begin
      if (rst)                    grQ[g] <= '0;
      else if (strobes.grLoad[g]) grQ[g] <= wrData;
      else if (capEv[g])          grQ[g] <= cntQ;
    end
  end

  assign cntVal = cntQ;
  assign grVal  = grQ;
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic [DATA_W-1:0]             cntVal,
  input  logic [NUM_GR-1:0][DATA_W-1:0] grVal,
  input  logic [NUM_GR-1:0]             capEv,
  input  logic [NUM_GR-1:0]             cmpEv,
  input  logic                          ovfEv,
  output ctlStrobes_t                   strobes,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid
);
  logic                runQ, pwmQ;
  logic [NUM_GR-1:0]   cmpModeQ;
  logic [NUM_FLAG-1:0] flagQ, armQ, flagNext, armNext, setVec, clrVec, wrField;
  logic                ctrlWr, statusWr, statusRd;
  logic [DATA_W-1:0]   rdNext;

  assign ctrlWr   = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
  assign statusWr = regWr && (regAddr == ADDR_W'(ADDR_STATUS));
  assign statusRd = regRd && (regAddr == ADDR_W'(ADDR_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ     <= 1'b0;
      pwmQ     <= 1'b0;
      cmpModeQ <= '0;
    end else if (ctrlWr) begin
      runQ     <= regWdata[CTL_RUN_BIT];
      pwmQ     <= regWdata[CTL_PWM_BIT];
      cmpModeQ <= regWdata[CTL_MODE_LSB +: NUM_GR];
    end
  end

  always_comb begin
    strobes.cntLoad = regWr && (regAddr == ADDR_W'(ADDR_CNT));
    strobes.countEn = runQ;
    strobes.pwmMode = pwmQ;
    strobes.cmpMode = cmpModeQ;
  end

  for (genvar g = 0; g < NUM_GR; g++) begin : gen_load
    assign strobes.grLoad[g] = regWr && (regAddr == ADDR_W'(ADDR_GR_BASE + g));
  end

  // flag index 0 is overflow, index 1+g is general register g
  assign setVec  = {(capEv | cmpEv) & {NUM_GR{~pwmQ}}, ovfEv};
  assign wrField = regWdata[OVF_BIT +: NUM_FLAG];
  assign clrVec  = statusWr ? (armQ & ~wrField) : '0;
  assign flagNext = setVec | (flagQ & ~clrVec);

  always_comb begin
    armNext = armQ;
    if (statusWr) armNext = armNext & wrField;
    if (statusRd) armNext = armNext | flagQ;
    armNext = armNext & flagNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
      armQ  <= '0;
    end else begin
      flagQ <= flagNext;
      armQ  <= armNext;
    end
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      rdNext[CTL_RUN_BIT]               = runQ;
      rdNext[CTL_PWM_BIT]               = pwmQ;
      rdNext[CTL_MODE_LSB +: NUM_GR]    = cmpModeQ;
    end else if (regAddr == ADDR_W'(ADDR_CNT)) begin
      rdNext = cntVal;
    end else if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      rdNext[OVF_BIT +: NUM_FLAG] = flagQ;
    end
    for (int g = 0; g < NUM_GR; g++) begin
      if (regAddr == ADDR_W'(ADDR_GR_BASE + g)) rdNext = grVal[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= regRd;
      if (regRd) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic [NUM_GR-1:0] capIn,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid
);
  ctlStrobes_t                  ctlStr;
  logic [CNT_W-1:0]             cntVal;
  logic [NUM_GR-1:0][CNT_W-1:0] grVal;
  logic [NUM_GR-1:0]            capEv, cmpEv;
  logic                         ovfEv;

  capcmp_ctrl #(.DATA_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .cntVal(cntVal), .grVal(grVal), .capEv(capEv),
    .cmpEv(cmpEv), .ovfEv(ovfEv), .strobes(ctlStr), .rdData(rdData),
    .rdValid(rdValid)
  );

  capcmp_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(ctlStr), .wrData(regWdata), .capIn(capIn),
    .cntVal(cntVal), .grVal(grVal), .capEv(capEv), .cmpEv(cmpEv), .ovfEv(ovfEv)
  );
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                regRd,
  input logic                rdValid,
  input ctlStrobes_t         strobes,
  input logic [CNT_W-1:0]    cntVal,
  input logic [NUM_FLAG-1:0] flagVec,
  input logic [NUM_FLAG-1:0] armVec,
  input logic [NUM_GR-1:0]   capEv,
  input logic [NUM_GR-1:0]   cmpEv
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.countEn && !strobes.cntLoad && !strobes.pwmMode) |=> (cntVal == $past(cntVal) + 1'b1));

  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobes.countEn && !strobes.cntLoad) |=> $stable(cntVal));

  a_r2_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    (strobes.countEn && !strobes.cntLoad && !strobes.pwmMode && cntVal == CNT_MAX) |=> flagVec[0]);

  a_r5_pwm_no_flag: assert property (@(posedge clk) disable iff (rst)
    strobes.pwmMode |=> ((flagVec[NUM_FLAG-1:1] & ~$past(flagVec[NUM_FLAG-1:1])) == '0));

  a_r6_unarmed_holds: assert property (@(posedge clk) disable iff (rst)
    ((flagVec & ~armVec) != '0) |=> (($past(flagVec & ~armVec) & ~flagVec) == '0));

  // covers R3 and R4 as well: an event outside PWM always leaves its flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (((capEv | cmpEv) != '0) && !strobes.pwmMode) |=> (($past(capEv | cmpEv) & ~flagVec[NUM_FLAG-1:1]) == '0));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdValid == $past(regRd)));
endmodule

bind capcmp_timer capcmp_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .regRd(regRd), .rdValid(rdValid), .strobes(ctlStr),
  .cntVal(cntVal), .flagVec(ctrl_i.flagQ), .armVec(ctrl_i.armQ),
  .capEv(capEv), .cmpEv(cmpEv)
);

// File: tb/capcmp_timer_tb.sv
`timescale 1ns/1ps
module capcmp_timer_tb_top;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_GRA = 3'd2, A_GRB = 3'd3,
                         A_GRC = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [2:0]  capIn = '0;
  logic [15:0] rdData;
  logic        rdValid;

  int checks = 0;
  int failures = 0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  capcmp_timer dut_i (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .capIn(capIn), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    expItem_t it;
    it.tag = tag; it.exp = e;
    expQ.push_back(it);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic runFor(input logic [15:0] base, input int k);
    wr(A_CTRL, base | 16'h0001);
    repeat (k - 1) @(negedge clk);
    wr(A_CTRL, base);
  endtask

  task automatic pulse(input int idx);
    capIn[idx] = 1'b1;
    repeat (3) @(negedge clk);
    capIn[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares read responses with queued expectations
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual=%h expected=none", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    rd(A_STAT, 16'h0000, "R9 status after reset");
    rd(A_CNT,  16'h0000, "R9 counter after reset");
    rd(A_CTRL, 16'h0000, "R9 control after reset");

    // R1: count 10 cycles then hold
    wr(A_CNT, 16'd100);
    runFor(16'h0000, 10);
    rd(A_CNT, 16'd110, "R1 counter after 10 cycles");
    repeat (5) @(negedge clk);
    rd(A_CNT, 16'd110, "R1 counter holds when stopped");

    // R2: wrap sets overflow, R6 read-then-clear
    wr(A_CNT, 16'hFFFE);
    runFor(16'h0000, 3);
    rd(A_CNT,  16'h0001, "R2 counter after wrap");
    rd(A_STAT, 16'h0200, "R2 overflow flag");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R6 cleared after read then write 0");

    // R6: write 0 without a prior read does nothing
    wr(A_CNT, 16'hFFFF);
    runFor(16'h0000, 1);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0200, "R6 unread flag survives write 0");
    // R7: writing 1 leaves an armed flag alone
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, 16'h0200, "R7 write 1 has no effect");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R6 cleared after arming");

    // R3: captures in capture mode with counter stopped
    wr(A_CNT, 16'h1234);
    pulse(1);
    rd(A_GRB,  16'h1234, "R3 register B captured");
    rd(A_STAT, 16'h0800, "R3 flag B set");
    wr(A_CNT, 16'h0042);
    pulse(0);
    rd(A_GRA,  16'h0042, "R3 register A captured");
    rd(A_STAT, 16'h0C00, "R3 flags A and B set");
    wr(A_STAT, 16'hF7FF);
    rd(A_STAT, 16'h0400, "R7 partial clear keeps A");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R6 A cleared later");

    // R4: compare match on register C
    wr(A_GRC, 16'h0050);
    wr(A_CNT, 16'h0048);
    runFor(16'h000E, 20);
    rd(A_CNT,  16'h005C, "R4 counter after run");
    rd(A_STAT, 16'h1000, "R4 flag C from compare");
    rd(A_CTRL, 16'h000E, "R10 control readback");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R6 C cleared");

    // R5: PWM period restart, no register flags, capture ignored
    wr(A_GRA, 16'h0010);
    wr(A_CNT, 16'h0000);
    runFor(16'h001E, 20);
    rd(A_CNT,  16'h0003, "R5 counter restarted at period");
    rd(A_STAT, 16'h0000, "R5 no flags in PWM");
    pulse(1);
    rd(A_GRB,  16'h1234, "R5 capture ignored in PWM");
    rd(A_STAT, 16'h0000, "R5 still no flags");
    rd(A_CTRL, 16'h001E, "R10 control with PWM");

    // R8: set and clear in the same cycle
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'hFFFF);
    runFor(16'h0000, 1);
    rd(A_STAT, 16'h0200, "R8 setup overflow flag");
    wr(A_CNT, 16'hFFFF);
    wr(A_CTRL, 16'h0001);
    wr(A_STAT, 16'h0000);
    wr(A_CTRL, 16'h0000);
    rd(A_CNT,  16'h0001, "R8 counter after wrap");
    rd(A_STAT, 16'h0200, "R8 set wins over clear");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R8 later clear works");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R10 missing responses: actual=%0d expected=0", expQ.size());
    end
    summary();
    $finish;
  end
endmodule